// File: doc/BRIEF.md
# Soft-Mute Gain Ramp

This block scales a pair of signed 16-bit audio channels by a shared gain of `g/64`. The gain index `g` is an integer that can take any value from 0 through 64. A mute request does not cut the signal at once. Instead, the index walks toward zero one level at a time, and dropping the request walks it back up to 64. The index moves only on sample strobes, and only once per sixteen of them. A full sweep between the two ends therefore always takes the same number of sample periods, whatever the clock rate.

The block sits in a sample pipeline and runs from a fast system clock. A one-cycle strobe marks each new sample pair. Each strobe captures the scaled samples into the output registers, and they hold there until the next strobe. A flag shows when the index has reached total silence.

Top module: `smute_ramp`

## Requirements
- R1: While `init_n` is low, both outputs are forced to zero at each clock edge, the index goes to 64, the strobe count goes to zero and `mute_flag` is low.
- R2: On a clock edge with `smp_stb` high, each output register loads `floor(sample*g/64)`, using the sample present with the strobe and the index value before that edge. This is an arithmetic shift right by 6 of the product, rounding toward negative infinity.
- R3: With the index at 64, each output equals its input sample exactly, including -32768 and 32767.
- R4: With the index at 0, both outputs are exactly zero for any input, and `mute_flag` is high exactly when the index is 0.
- R5: The index can change only on the 16th strobe counted since init, and then on every 16th strobe after that. When `mute_req` is high at that strobe, the index drops by one, down to a floor of 0.
- R6: When `mute_req` is low at a stepping strobe, the index rises by one, up to a ceiling of 64, where it stays.
- R7: After init with `mute_req` held high, `mute_flag` first goes high on exactly the 1024th strobe.
- R8: Changing `mute_req` partway through a ramp reverses it from the current index, and no level is skipped.
- R9: Both channels are scaled by the same index, each from its own sample.
- R10: Without a strobe, the outputs, the index and `mute_flag` all hold, whatever `mute_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| init_n | input | 1 | Synchronous initialisation, active low |
| mute_req | input | 1 | High requests a ramp down to silence; low requests a ramp up to unity |
| smp_stb | input | 1 | One-cycle sample strobe |
| in_l | input | 16 | Left sample, two's complement |
| in_r | input | 16 | Right sample, two's complement |
| out_l | output | 16 | Scaled left sample, registered |
| out_r | output | 16 | Scaled right sample, registered |
| mute_flag | output | 1 | High when the gain index is 0 |

## Verification
The left input is held at +64 during the ramps, so the left output shows the gain index directly. This makes an off-by-one divider visible, as a full ramp would then take a strobe count other than 1024. It also shows a reversal that skips or repeats a level, and an index that wraps past 0 or 64 instead of saturating. The right channel carries negative odd values, which separate floor rounding from truncation toward zero. Long gaps without strobes, with the mute request toggled during them, would expose a design that steps on plain clock cycles rather than on strobes.

// File: rtl/smute_pkg.sv
package smute_pkg;

    localparam int SMP_W    = 16;
    localparam int IDX_MAX  = 64;
    localparam int STEP_DIV = 16;

    localparam int IDX_W    = $clog2(IDX_MAX + 1);
    localparam int SHIFT    = $clog2(IDX_MAX);
    localparam int CNT_W    = $clog2(STEP_DIV);

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_e;

    typedef struct packed {
        logic      step;
        ramp_dir_e dir;
    } ramp_cmd_t;

endpackage

// File: rtl/smute_pacer.sv
module smute_pacer
    import smute_pkg::*;
#(
    parameter int DIV = STEP_DIV
) (
    input  logic clk,
    input  logic init_n,
    input  logic stb,
    output logic step
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!init_n) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);
        end
    end

    assign step = stb && (cnt == CW'(DIV - 1));

endmodule

// File: rtl/smute_index.sv
module smute_index
    import smute_pkg::*;
#(
    parameter int IMAX = IDX_MAX,
    parameter int IW   = $clog2(IMAX + 1)
) (
    input  logic          clk,
    input  logic          init_n,
    input  ramp_cmd_t     cmd,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (!init_n) begin
            idx <= IW'(IMAX);
        end else if (cmd.step) begin
            if (cmd.dir == RAMP_DOWN && idx != '0) begin
                idx <= idx - IW'(1);
            end else if (cmd.dir == RAMP_UP && idx != IW'(IMAX)) begin
                idx <= idx + IW'(1);
            end
        end
    end

    // R5
    idx_down_chk: assert property (@(posedge clk) disable iff (!init_n)
        (cmd.step && cmd.dir == RAMP_DOWN && idx != '0) |=> (idx == $past(idx) - IW'(1)));

    // R6
    idx_up_chk: assert property (@(posedge clk) disable iff (!init_n)
        (cmd.step && cmd.dir == RAMP_UP && idx != IW'(IMAX)) |=> (idx == $past(idx) + IW'(1)));

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (!init_n)
        !cmd.step |=> $stable(idx));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!init_n)
        idx <= IW'(IMAX));

endmodule

// File: rtl/smute_scaler.sv
module smute_scaler
    import smute_pkg::*;
#(
    parameter int SW  = SMP_W,
    parameter int IW  = IDX_W,
    parameter int SH  = SHIFT,
    parameter int IMX = IDX_MAX
) (
    input  logic                 clk,
    input  logic                 init_n,
    input  logic                 stb,
    input  logic [IW-1:0]        idx,
    input  logic signed [SW-1:0] sample,
    output logic signed [SW-1:0] scaled
);
    localparam int PW = SW + IW + 1;

    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] shifted;

    assign prod    = PW'(sample) * PW'($signed({1'b0, idx}));
    assign shifted = prod[SH+SW-1:SH];

    always_ff @(posedge clk) begin
        if (!init_n) begin
            scaled <= '0;
        end else if (stb) begin
            scaled <= shifted;
        end
    end

    // R3
    unity_pass_chk: assert property (@(posedge clk) disable iff (!init_n)
        (stb && idx == IW'(IMX)) |=> (scaled == $past(sample)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!init_n)
        !stb |=> $stable(scaled));

endmodule

// File: rtl/smute_ramp.sv
module smute_ramp
    import smute_pkg::*;
(
    input  logic                    clk,
    input  logic                    init_n,
    input  logic                    mute_req,
    input  logic                    smp_stb,
    input  logic signed [SMP_W-1:0] in_l,
    input  logic signed [SMP_W-1:0] in_r,
    output logic signed [SMP_W-1:0] out_l,
    output logic signed [SMP_W-1:0] out_r,
    output logic                    mute_flag
);
    localparam int NUM_CH = 2;

    logic                    step;
    ramp_cmd_t               cmd;
    logic [IDX_W-1:0]        idx;
    logic signed [SMP_W-1:0] ch_in  [NUM_CH];
    logic signed [SMP_W-1:0] ch_out [NUM_CH];

    smute_pacer #(.DIV(STEP_DIV)) pacer_i (
        .clk    (clk),
        .init_n (init_n),
        .stb    (smp_stb),
        .step   (step)
    );

    assign cmd.step = step;
    assign cmd.dir  = mute_req ? RAMP_DOWN : RAMP_UP;

    smute_index #(.IMAX(IDX_MAX), .IW(IDX_W)) index_i (
        .clk    (clk),
        .init_n (init_n),
        .cmd    (cmd),
        .idx    (idx)
    );

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        smute_scaler #(.SW(SMP_W), .IW(IDX_W), .SH(SHIFT), .IMX(IDX_MAX)) scaler_i (
            .clk    (clk),
            .init_n (init_n),
            .stb    (smp_stb),
            .idx    (idx),
            .sample (ch_in[c]),
            .scaled (ch_out[c])
        );
    end

    assign out_l     = ch_out[0];
    assign out_r     = ch_out[1];
    assign mute_flag = (idx == '0);

    // R1
    init_zero_chk: assert property (@(posedge clk)
        !init_n |=> (out_l == '0 && out_r == '0 && !mute_flag));

    // R4
    silence_chk: assert property (@(posedge clk) disable iff (!init_n)
        (smp_stb && mute_flag) |=> (out_l == '0 && out_r == '0));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!init_n)
        !smp_stb |=> $stable(mute_flag));

endmodule

// File: tb/smute_ramp_tb.sv
`timescale 1ns/1ps
module smute_ramp_tb_top;

    logic clk = 1'b0;
    logic init_n = 1'b0;
    logic mute_req = 1'b0;
    logic smp_stb = 1'b0;
    logic signed [15:0] in_l = '0;
    logic signed [15:0] in_r = '0;
    logic signed [15:0] out_l;
    logic signed [15:0] out_r;
    logic mute_flag;

    int n_chk = 0;
    int n_fail = 0;
    int m_idx = 64;
    int m_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smute_ramp dut_i (
        .clk(clk), .init_n(init_n), .mute_req(mute_req), .smp_stb(smp_stb),
        .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r), .mute_flag(mute_flag)
    );

    typedef struct packed { logic signed [15:0] l; logic signed [15:0] r; } vec_t;
    localparam vec_t VEC [8] = '{
        '{16'sd0, 16'sd1}, '{16'sd32767, -16'sd32768}, '{-16'sd1, 16'sd1000},
        '{16'sd12345, -16'sd12345}, '{-16'sd32768, 16'sd32767}, '{16'sd64, -16'sd63},
        '{-16'sd7, 16'sd7}, '{16'sd255, -16'sd256}
    };

    function automatic int exp_scale(int s, int g);
        int p = s * g;
        int q = p / 64;
        if (p < 0 && (p % 64) != 0) q = q - 1;
        return q;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic strobe(int l, int r, string req);
        int el, er;
        @(negedge clk);
        smp_stb = 1'b1; in_l = 16'(l); in_r = 16'(r);
        el = exp_scale(l, m_idx);
        er = exp_scale(r, m_idx);
        m_cnt++;
        if (m_cnt == 16) begin
            m_cnt = 0;
            if (mute_req && m_idx > 0) m_idx--;
            else if (!mute_req && m_idx < 64) m_idx++;
        end
        @(negedge clk);
        smp_stb = 1'b0;
        chk(int'(out_l) == el, req, int'(out_l), el);
        chk(int'(out_r) == er, req, int'(out_r), er);
        chk(mute_flag == (m_idx == 0), "R4 flag", int'(mute_flag), int'(m_idx == 0));
    endtask

    task automatic do_init();
        @(negedge clk);
        init_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            smp_stb = 1'b1; in_l = 16'sd1234; in_r = -16'sd999;
            @(negedge clk);
            chk(out_l == 0 && out_r == 0, "R1 outputs", int'(out_l), 0);
            chk(mute_flag == 1'b0, "R1 flag", int'(mute_flag), 0);
        end
        smp_stb = 1'b0;
        m_idx = 64; m_cnt = 0;
        init_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual expired expected finished");
            summary();
        end
    end

    initial begin
        int n;
        int prev;
        do_init();
        mute_req = 1'b0;

        // R3 / R2: table walk at unity gain
        foreach (VEC[i]) begin
            strobe(int'(VEC[i].l), int'(VEC[i].r), "R3 unity");
            chk(out_l == VEC[i].l && out_r == VEC[i].r, "R3 exact", int'(out_l), int'(VEC[i].l));
        end

        // R5 / R7: full ramp down, left shows index
        do_init();
        mute_req = 1'b1;
        n = 0;
        while (!mute_flag && n < 2000) begin
            strobe(64, -(2 * n + 1) % 32768, "R5 R9 ramp down");
            n++;
        end
        chk(n == 1024, "R7 ramp length", n, 1024);

        // R4: full mute gives zero for extreme inputs
        strobe(32767, -32768, "R4 silence");
        chk(out_l == 0 && out_r == 0, "R4 zero", int'(out_l), 0);

        // R10: no strobes, toggle mute, everything holds
        mute_req = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            in_l = 16'(i * 37); in_r = 16'(-i);
            mute_req = i[0];
            chk(out_l == 0 && out_r == 0 && mute_flag, "R10 hold", int'(out_l), 0);
        end
        mute_req = 1'b0;

        // R6: ramp up partway
        for (int i = 0; i < 320; i++) strobe(64, -101, "R6 ramp up");

        // R8: reverse mid-ramp, no level skipped
        mute_req = 1'b1;
        prev = int'(out_l);
        for (int i = 0; i < 200; i++) begin
            strobe(64, -3, "R8 reversal");
            chk(prev - int'(out_l) <= 1 && int'(out_l) <= prev, "R8 step", int'(out_l), prev);
            prev = int'(out_l);
        end

        // R6: release and saturate at 64
        mute_req = 1'b0;
        for (int i = 0; i < 1200; i++) strobe(64, 33, "R6 up to unity");
        chk(out_l == 64, "R6 saturate", int'(out_l), 64);

        done = 1'b1;
        summary();
    end

endmodule